// File: doc/BRIEF.md
# Buffer Load-Status Toggle Responder

This block sits on the device side of a 16-bit asynchronous read port. It reports whether an internal page load into one of three buffer regions is still in progress. A load command written on the command port starts a busy period, and a single-cycle load-done input ends it. While the busy period lasts, each completed asynchronous read of the buffer region named by the buffer-select register returns the stored word with bit 6 replaced by a toggle flag. The flag inverts after every such read. A host polls one address and watches bit 6 change. When bit 6 stops changing, the load has finished.

Reads of regions that are not selected pass their stored data through unchanged. In cache-read mode and in synchronous burst mode the toggle is suppressed. For a settling window after each load starts, reads of the selected region return an all-zero word. That window is a fixed number of nanoseconds, converted into clock cycles. A cold reset counts as the start of a boot-code copy into the boot region, so the toggle is visible straight out of reset.

Top module: `ld_toggle_responder`

## Requirements
- R1: After reset, busy is 1, the buffer-select register holds code 0 (boot region), the toggle flag is 0 and the settling window begins, so the boot region shows the toggle with no command.
- R2: Writing command code 0x0000 or 0x0013 with cmd_wr while idle sets busy on the next cycle. Any other code leaves busy at 0.
- R3: A load command written while busy is ignored. Neither the toggle flag nor the settling window restarts.
- R4: A load_done pulse clears busy. While idle, every read returns ram_data unchanged.
- R5: Region decode is: boot at word addresses 0x000–0x00F, data 0 at 0x200–0x21F, data 1 at 0x600–0x61F. Buffer-select codes are 0 = boot, 1 = data 0, 2 = data 1, 3 = none. Addresses just outside a region are not decoded as that region.
- R6: While busy, after the settling window, in asynchronous mode, a read of the selected region returns ram_data with bit 6 replaced by the toggle flag. The flag is 0 at each load start and inverts on the rising edge of rd_stb_n that ends each such read.
- R7: During a busy period, reads of regions other than the selected one return ram_data unchanged.
- R8: For ceil(350 ns / clock period) cycles after a load start (70 cycles at 5 ns), reads of the selected region return 0x0000 and do not advance the toggle flag.
- R9: While mode_cache_rd or mode_sync_burst is 1, every read returns ram_data unchanged and the toggle flag does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (cold reset) |
| cmd_wr | input | 1 | Command write strobe, one cycle |
| cmd_data | input | 16 | Command code |
| sel_wr | input | 1 | Buffer-select register write strobe |
| sel_data | input | 2 | Buffer-select code (0 boot, 1 data 0, 2 data 1, 3 none) |
| load_done | input | 1 | Pulse marking the end of the internal load |
| mode_cache_rd | input | 1 | Cache-read mode active |
| mode_sync_burst | input | 1 | Synchronous burst read mode active |
| rd_stb_n | input | 1 | Active-low read strobe, sampled by clk |
| rd_addr | input | 16 | Word read address |
| ram_data | input | 16 | Stored word at rd_addr |
| rd_data | output | 16 | Read data returned to the host |
| busy | output | 1 | Load in progress |

## Verification
The bench reads the first and last word of each region and the word just outside each end. A decoder that is off by one leaks the toggle into a neighbouring address, or drops it at a region edge. It reads during the settling window and again after it, so a missing or mis-sized window shows up as a wrong zero or a wrong toggle value. A load command is reissued mid-load, and a design that restarts on it returns zeros or a toggle sequence that starts again from 0. Reads in cache-read and burst modes are placed between toggling reads, so a design that advances the flag in those modes breaks the alternating sequence that follows.

// File: rtl/ld_pkg.sv
// Package: shared types and the region map for the load-status responder.
// Assumes word addressing and exactly three buffer regions.
package ld_pkg;

    typedef enum logic [1:0] {
        BUF_BOOT  = 2'd0,
        BUF_DATA0 = 2'd1,
        BUF_DATA1 = 2'd2,
        BUF_NONE  = 2'd3
    } buf_sel_e;

    localparam int NUM_REGIONS = 3;

    // First word address of region i.
    function automatic logic [15:0] region_base(input int i);
        case (i)
            0:       return 16'h0000;
            1:       return 16'h0200;
            default: return 16'h0600;
        endcase
    endfunction

    // Number of words in region i.
    function automatic logic [15:0] region_size(input int i);
        case (i)
            0:       return 16'h0010;
            default: return 16'h0020;
        endcase
    endfunction

endpackage

// File: rtl/ld_region_decode.sv
// Module: decodes a word address into one hit flag per buffer region.
// Assumes the regions do not overlap. Purely combinational.
module ld_region_decode #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0]              addr,
    output logic [ld_pkg::NUM_REGIONS-1:0] hit
);
    for (genvar g = 0; g < ld_pkg::NUM_REGIONS; g++) begin : g_region
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(ld_pkg::region_base(g));
        localparam logic [ADDR_W-1:0] SIZE = ADDR_W'(ld_pkg::region_size(g));
        logic [ADDR_W-1:0] offset;
        // Offset from the region base; wraps below the base, so one compare suffices.
        assign offset = addr - BASE;
        assign hit[g] = (offset < SIZE);
    end
endmodule

// File: rtl/ld_guard_timer.sv
// Module: counts the settling window after each load start.
// done goes high GUARD_CYC cycles after restart, or after reset, and stays high.
module ld_guard_timer #(
    parameter int GUARD_CYC = 70
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic done
);
    localparam int CNT_W = $clog2(GUARD_CYC + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(GUARD_CYC);

    logic [CNT_W-1:0] cnt_q;

    // Count up to the limit, restarting from zero on a new load.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == LIMIT);
endmodule

// File: rtl/ld_toggle_core.sv
// Module: the per-read toggle flag. It records whether a read qualified while
// the strobe was low, and inverts the flag on the strobe's rising edge.
// Assumes rd_stb_n is already synchronous to clk.
module ld_toggle_core (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic rd_stb_n,
    input  logic qualify,
    output logic tog_q
);
    logic stb_q;
    logic hit_q;

    // Delay the strobe by one cycle to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b1;
        else        stb_q <= rd_stb_n;
    end

    // Hold whether the current read qualified for the toggle.
    always_ff @(posedge clk) begin
        if (!rst_n)        hit_q <= 1'b0;
        else if (!rd_stb_n) hit_q <= qualify;
    end

    // Clear at load start; invert when a qualifying read ends.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)                  tog_q <= 1'b0;
        else if (rd_stb_n && !stb_q && hit_q) tog_q <= ~tog_q;
    end
endmodule

// File: rtl/ld_toggle_responder.sv
// Top: load-status toggle responder. It holds the busy flag and the
// buffer-select register, and forms the read word for the host.
// Assumes ram_data is the stored word at rd_addr in the same cycle.
module ld_toggle_responder #(
    parameter int          ADDR_W        = 16,
    parameter int          DATA_W        = 16,
    parameter int          TOG_BIT       = 6,
    parameter int          CLK_PERIOD_PS = 5000,
    parameter int          GUARD_NS      = 350,
    parameter logic [15:0] LOAD_CODE_A   = 16'h0000,
    parameter logic [15:0] LOAD_CODE_B   = 16'h0013
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [15:0]       cmd_data,
    input  logic              sel_wr,
    input  logic [1:0]        sel_data,
    input  logic              load_done,
    input  logic              mode_cache_rd,
    input  logic              mode_sync_burst,
    input  logic              rd_stb_n,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] ram_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);
    import ld_pkg::*;

    localparam int GUARD_CYC = (GUARD_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;

    buf_sel_e                 sel_q;
    logic                     busy_q;
    logic                     load_start;
    logic                     async_mode;
    logic                     hit_sel;
    logic                     guard_done;
    logic                     tog_q;
    logic                     toggling;
    logic [NUM_REGIONS-1:0]   hit;

    // A load starts on a recognised code, and only while idle.
    assign load_start = cmd_wr && !busy_q &&
                        (cmd_data == LOAD_CODE_A || cmd_data == LOAD_CODE_B);
    assign async_mode = !mode_cache_rd && !mode_sync_burst;

    // Busy flag: set by a load start, cleared by load_done; busy out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          busy_q <= 1'b1;
        else if (load_start) busy_q <= 1'b1;
        else if (load_done)  busy_q <= 1'b0;
    end

    // Buffer-select register; the boot region is selected out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= BUF_BOOT;
        else if (sel_wr) sel_q <= buf_sel_e'(sel_data);
    end

    ld_region_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (rd_addr),
        .hit  (hit)
    );

    // Pick the hit flag of the selected region.
    always_comb begin
        case (sel_q)
            BUF_BOOT:  hit_sel = hit[0];
            BUF_DATA0: hit_sel = hit[1];
            BUF_DATA1: hit_sel = hit[2];
            default:   hit_sel = 1'b0;
        endcase
    end

    ld_guard_timer #(.GUARD_CYC(GUARD_CYC)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load_start),
        .done    (guard_done)
    );

    assign toggling = busy_q && async_mode && hit_sel;

    ld_toggle_core u_toggle (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (load_start),
        .rd_stb_n (rd_stb_n),
        .qualify  (toggling && guard_done),
        .tog_q    (tog_q)
    );

    // Read word: zero inside the window, toggle bit after it, else stored data.
    always_comb begin
        rd_data = ram_data;
        if (toggling) begin
            if (!guard_done) rd_data = '0;
            else             rd_data[TOG_BIT] = tog_q;
        end
    end

    assign busy = busy_q;
endmodule

// File: rtl/ld_toggle_responder_chk.sv
// Checker: temporal properties of the load-status responder, bound to the top.
// Assumes the default load codes and a 16-bit data path.
module ld_toggle_responder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wr,
    input logic [15:0] cmd_data,
    input logic        load_done,
    input logic        mode_cache_rd,
    input logic        mode_sync_burst,
    input logic [15:0] ram_data,
    input logic [15:0] rd_data,
    input logic        busy,
    input logic        hit_sel,
    input logic        guard_done
);
    AST_LOAD_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && (cmd_data == 16'h0000 || cmd_data == 16'h0013)) |=> busy); // R2
    AST_BUSY_CMD_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy && guard_done) |=> guard_done); // R3
    AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done && busy && !cmd_wr) |=> !busy); // R4
    AST_IDLE_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rd_data == ram_data)); // R4
    AST_UNSEL_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_sel |-> (rd_data == ram_data)); // R7
    AST_GUARD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hit_sel && !guard_done && !mode_cache_rd && !mode_sync_burst)
        |-> (rd_data == 16'h0000)); // R8
    AST_MODE_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cache_rd || mode_sync_burst) |-> (rd_data == ram_data)); // R9
    AST_TOG_ONLY_BIT6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && guard_done) |-> ((rd_data & 16'hFFBF) == (ram_data & 16'hFFBF))); // R6
endmodule

bind ld_toggle_responder ld_toggle_responder_chk u_chk (.*);

// File: tb/ld_toggle_responder_tb.sv
// Bench: a scoreboard. Driver tasks push expected words into a queue, and a
// monitor pops and compares them when each read is sampled.
module ld_toggle_responder_tb;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [15:0] cmd_data = '0;
    logic        sel_wr = 1'b0;
    logic [1:0]  sel_data = '0;
    logic        load_done = 1'b0;
    logic        mode_cache_rd = 1'b0;
    logic        mode_sync_burst = 1'b0;
    logic        rd_stb_n = 1'b1;
    logic [15:0] rd_addr = '0;
    logic [15:0] ram_data;
    logic [15:0] rd_data;
    logic        busy;

    int    checks = 0;
    int    errors = 0;
    item_t sb_q[$];
    event  sample_ev;

    // Bench model state.
    bit       m_busy, m_tog, m_guard_ok;
    bit [1:0] m_sel;

    always #2.5 clk = ~clk;

    function automatic logic [15:0] stored(input logic [15:0] a);
        return (a * 16'h9E37) ^ 16'h3C5A;
    endfunction

    assign ram_data = stored(rd_addr);

    ld_toggle_responder u_dut (
        .clk, .rst_n, .cmd_wr, .cmd_data, .sel_wr, .sel_data, .load_done,
        .mode_cache_rd, .mode_sync_burst, .rd_stb_n, .rd_addr, .ram_data,
        .rd_data, .busy
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compares each sampled read with the queued expectation.
    initial begin
        forever begin
            item_t it;
            @(sample_ev);
            it = sb_q.pop_front();
            check(rd_data === it.exp, it.tag, rd_data, it.exp);
        end
    end

    function automatic bit in_sel(input logic [15:0] a, input bit [1:0] s);
        case (s)
            2'd0:    return a <= 16'h000F;
            2'd1:    return a >= 16'h0200 && a <= 16'h021F;
            2'd2:    return a >= 16'h0600 && a <= 16'h061F;
            default: return 1'b0;
        endcase
    endfunction

    task automatic do_read(input logic [15:0] a, input string tag);
        item_t it;
        bit    act;
        act    = m_busy && !mode_cache_rd && !mode_sync_burst && in_sel(a, m_sel);
        it.exp = stored(a);
        it.tag = tag;
        if (act && !m_guard_ok) it.exp = 16'h0000;
        else if (act)           it.exp[6] = m_tog;
        rd_addr  = a;
        rd_stb_n = 1'b0;
        @(negedge clk);
        sb_q.push_back(it);
        -> sample_ev;
        #0.1;
        rd_stb_n = 1'b1;
        @(negedge clk);
        if (act && m_guard_ok) m_tog = ~m_tog;
    endtask

    task automatic do_cmd(input logic [15:0] code);
        cmd_wr   = 1'b1;
        cmd_data = code;
        @(negedge clk);
        cmd_wr = 1'b0;
        if (!m_busy && (code == 16'h0000 || code == 16'h0013)) begin
            m_busy = 1; m_tog = 0; m_guard_ok = 0;
        end
    endtask

    task automatic do_sel(input bit [1:0] s);
        sel_wr = 1'b1; sel_data = s;
        @(negedge clk);
        sel_wr = 1'b0; m_sel = s;
    endtask

    task automatic do_done();
        load_done = 1'b1;
        @(negedge clk);
        load_done = 1'b0; m_busy = 0;
    endtask

    task automatic wait_guard();
        repeat (80) @(negedge clk);
        m_guard_ok = 1;
    endtask

    task automatic check_busy(input bit exp, input string tag);
        check(busy === exp, tag, {15'd0, busy}, {15'd0, exp});
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // Driver: stimulus sequence.
    initial begin
        m_busy = 1; m_sel = 0; m_tog = 0; m_guard_ok = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check_busy(1'b1, "R1 busy after reset");
        do_read(16'h0003, "R8 boot read inside window after reset");
        do_read(16'h0205, "R7 unselected data0 during boot copy");
        wait_guard();
        do_read(16'h0000, "R1 R6 boot toggle first read");
        do_read(16'h000F, "R5 R6 boot last word toggles");
        do_read(16'h0007, "R6 boot toggle third read");
        do_read(16'h0010, "R5 word past boot region");
        mode_cache_rd = 1'b1;
        do_read(16'h0004, "R9 cache mode passthrough");
        mode_cache_rd = 1'b0; mode_sync_burst = 1'b1;
        do_read(16'h0004, "R9 burst mode passthrough");
        mode_sync_burst = 1'b0;
        do_read(16'h0004, "R9 toggle not advanced by mode reads");
        do_done();
        check_busy(1'b0, "R4 busy cleared by load_done");
        do_read(16'h0004, "R4 idle read passthrough");
        do_cmd(16'h0007);
        check_busy(1'b0, "R2 non-load code ignored");
        do_sel(2'd1);
        do_cmd(16'h0013);
        check_busy(1'b1, "R2 code 0x0013 starts load");
        do_read(16'h0200, "R8 data0 read inside window");
        wait_guard();
        do_read(16'h0200, "R5 R6 data0 first word");
        do_read(16'h021F, "R5 R6 data0 last word");
        do_read(16'h0220, "R5 word past data0");
        do_read(16'h01FF, "R5 word before data0");
        do_read(16'h0008, "R7 unselected boot during data0 load");
        do_cmd(16'h0000);
        check_busy(1'b1, "R3 busy held on repeated command");
        do_read(16'h0210, "R3 toggle continues after ignored command");
        do_read(16'h0211, "R3 toggle continues second read");
        do_done();
        do_sel(2'd2);
        do_cmd(16'h0000);
        check_busy(1'b1, "R2 code 0x0000 starts load");
        wait_guard();
        do_read(16'h0600, "R5 R6 data1 first word");
        do_read(16'h061F, "R5 R6 data1 last word");
        do_read(16'h0610, "R6 data1 third read");
        do_read(16'h0620, "R5 word past data1");
        do_read(16'h05FF, "R5 word before data1");
        do_read(16'h0205, "R7 unselected data0 during data1 load");
        do_done();
        do_sel(2'd3);
        do_cmd(16'h0013);
        wait_guard();
        do_read(16'h0000, "R5 select none boot passthrough");
        do_read(16'h0200, "R5 select none data0 passthrough");
        do_read(16'h0600, "R5 select none data1 passthrough");
        do_done();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule